// File: doc/BRIEF.md
# Serial Port Control Register with Synchronized Commands

This block is the control word of a serial port as software sees it on the register bus. It holds the frame settings: character size, stop-bit count, parity sense, start-of-frame detection, infrared encoding and collision detection. It also holds the receiver and transmitter enable bits and two command fields. One command field clears the transmit or receive FIFO. The other starts a line break or a full header on the line.

While the port is off, a write takes effect at once and the busy flag never rises. While the port is on, the frame settings are locked. Command and enable writes are sent to the serial side by toggling a request. The request passes through a `SYNC_STAGES`-deep synchronizer. The serial side applies the command and waits until the transmitter and receiver cores report the enable levels it asked for. It then returns an acknowledge toggle through a second synchronizer of the same depth. Busy stays high from the write until that acknowledge arrives. A write issued while busy is dropped and answered with a one-cycle bus error.

Register layout, in bits:
- bit 0: transmitter enable
- bit 1: receiver enable
- bits 3:2: FIFO clear
- bits 5:4: line command
- bits 10:8: character size
- bit 11: two stop bits
- bit 12: odd parity
- bit 13: collision detect
- bit 14: start-of-frame detect
- bit 15: infrared encoding

Top module: `serial_ctl_reg`

## Requirements
- R1: A write presented while `busy` is high changes no register state and no core output, and `bus_err` is high in the following cycle.
- R2: The line-command field (bits 5:4) always reads 0. Writing 1 gives a one-cycle `lin_cmd`=1 (break) on the serial side, and writing 2 gives `lin_cmd`=2 (break, sync and identifier). Writing 3 gives no pulse.
- R3: The FIFO-clear field (bits 3:2) makes one-cycle pulses on the serial side. 1 pulses `tx_fifo_clr`, 2 pulses `rx_fifo_clr` and 3 pulses both. With the port off the field reads 0 at once. With the port on it reads the written value while busy and reads 0 once busy falls.
- R4: With `port_en` low, a write updates the enable bits (bit 0 transmit, bit 1 receive) and `tx_core_en`/`rx_core_en` in the same clock edge, and `busy` stays low.
- R5: With `port_en` high, a write accepted at one edge makes `busy` high after that edge. An enable bit written 1 from 0 reads 0 until the core acknowledge matches, then reads 1. A bit already 1 that is written 1 keeps reading 1.
- R6: Clearing the receiver enable gives a one-cycle `rx_flush` pulse when `rx_core_en` falls. This pulse flushes the receive buffer and FIFO and clears the frame, parity and overflow error flags.
- R7: Clearing the transmitter enable makes bit 0 read 0 at once, and from then on `data_wr` is not passed to `tx_data_wr`. `busy` stays high until `tx_ack` falls, which happens when the core has sent its ongoing and pending frames.
- R8: With collision detection on (bit 13), a `coll_in` cycle clears bit 0, drops `tx_core_en` and sets `coll_flag`. An accepted write with bit 0 set clears `coll_flag`.
- R9: The frame fields (bits 15:8) are written only while `port_en` is low. While it is high, they keep their value through any write.
- R10: After reset every register bit and every output is 0. Bits 31:16 and 7:6 always read 0 and ignore writes.
- R11: With the port on, a command pulse appears on the serial side `SYNC_STAGES`+1 cycles after the edge that accepted the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| bus_err | output | 1 | One-cycle error for a write rejected while busy |
| busy | output | 1 | Cross-domain update in flight |
| port_en | input | 1 | Serial port is enabled |
| data_wr | input | 1 | Host data write toward the transmitter |
| tx_data_wr | output | 1 | Data write passed to the transmitter |
| coll_in | input | 1 | Collision seen by the transmitter |
| coll_flag | output | 1 | Sticky collision status |
| rx_ack | input | 1 | Receiver reports it is running |
| tx_ack | input | 1 | Transmitter reports it is running |
| rx_core_en | output | 1 | Enable level to the receiver core |
| tx_core_en | output | 1 | Enable level to the transmitter core |
| tx_fifo_clr | output | 1 | Clear pulse for the transmit FIFO |
| rx_fifo_clr | output | 1 | Clear pulse for the receive FIFO |
| rx_flush | output | 1 | Receive flush and error-flag clear pulse |
| lin_cmd | output | 2 | Line command pulse: 1 break, 2 full header |
| char_size | output | 3 | Character size setting |
| two_stop | output | 1 | Two stop bits |
| parity_odd | output | 1 | Odd parity selected |
| sof_det_en | output | 1 | Start-of-frame detection enabled |
| ir_enc_en | output | 1 | Infrared encoding enabled |
| coll_det_en | output | 1 | Collision detection enabled |

## Verification
The bench attacks the read-back rules of the enable bits.

A design that set an enable bit immediately with the port on would show bit 0 or 1 as 1 while busy. A design that cleared an already-set bit would show a 0 there. A design that ignored busy during a transmitter drain would drop `busy` while `tx_ack` is still held high.

Writes issued while busy must return `bus_err` and leave the enables alone. A design that queued them would later turn the receiver on. The strobe fields are checked for both their read value and their pulse count. A FIFO-clear field that never clears would read non-zero after busy falls, and a reserved line command would give a stray pulse.

The cycle of the first serial-side pulse pins down the synchronizer depth. Collision handling must also win over a pending enable.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int REG_W     = 32;
    localparam int CSZ_W     = 3;
    localparam int TXEN_BIT  = 0;
    localparam int RXEN_BIT  = 1;
    localparam int FCLR_LSB  = 2;
    localparam int LIN_LSB   = 4;
    localparam int CSZ_LSB   = 8;
    localparam int STOP2_BIT = 11;
    localparam int PODD_BIT  = 12;
    localparam int COLL_BIT  = 13;
    localparam int SOF_BIT   = 14;
    localparam int IRENC_BIT = 15;

    typedef enum logic [1:0] {
        FCLR_NONE = 2'd0,
        FCLR_TX   = 2'd1,
        FCLR_RX   = 2'd2,
        FCLR_BOTH = 2'd3
    } fclr_e;

    typedef enum logic [1:0] {
        LIN_IDLE   = 2'd0,
        LIN_BREAK  = 2'd1,
        LIN_HEADER = 2'd2,
        LIN_RSVD   = 2'd3
    } lin_e;

    typedef struct packed {
        logic             ir_enc;
        logic             sof_det;
        logic             coll_det;
        logic             par_odd;
        logic             stop2;
        logic [CSZ_W-1:0] char_size;
    } frame_t;

    typedef struct packed {
        logic  rx_en;
        logic  tx_en;
        fclr_e fclr;
        lin_e  lin;
    } cmd_t;

    function automatic frame_t frame_from_word(input logic [REG_W-1:0] w);
        frame_t f;
        f.char_size = w[CSZ_LSB +: CSZ_W];
        f.stop2     = w[STOP2_BIT];
        f.par_odd   = w[PODD_BIT];
        f.coll_det  = w[COLL_BIT];
        f.sof_det   = w[SOF_BIT];
        f.ir_enc    = w[IRENC_BIT];
        return f;
    endfunction

    function automatic cmd_t cmd_from_word(input logic [REG_W-1:0] w);
        cmd_t c;
        c.rx_en = w[RXEN_BIT];
        c.tx_en = w[TXEN_BIT];
        c.fclr  = fclr_e'(w[FCLR_LSB +: 2]);
        c.lin   = lin_e'(w[LIN_LSB +: 2]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] word_from_state(
        input frame_t f,
        input fclr_e  fc,
        input logic   rx,
        input logic   tx
    );
        logic [REG_W-1:0] w;
        w                      = '0;
        w[TXEN_BIT]            = tx;
        w[RXEN_BIT]            = rx;
        w[FCLR_LSB +: 2]       = fc;
        w[CSZ_LSB +: CSZ_W]    = f.char_size;
        w[STOP2_BIT]           = f.stop2;
        w[PODD_BIT]            = f.par_odd;
        w[COLL_BIT]            = f.coll_det;
        w[SOF_BIT]             = f.sof_det;
        w[IRENC_BIT]           = f.ir_enc;
        return w;
    endfunction

    function automatic logic fclr_hits_tx(input fclr_e f);
        return (f == FCLR_TX) || (f == FCLR_BOTH);
    endfunction

    function automatic logic fclr_hits_rx(input fclr_e f);
        return (f == FCLR_RX) || (f == FCLR_BOTH);
    endfunction

endpackage

// File: rtl/sctl_tgl_sync.sv
module sctl_tgl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic tgl_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= tgl_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], tgl_in};
            end
        end
    endgenerate

    assign tgl_out = chain_q[STAGES-1];
endmodule

// File: rtl/sctl_host_regs.sv
module sctl_host_regs
    import sctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             port_en,
    input  logic             coll_hit,
    input  logic             ack_tgl_sync,
    output logic [REG_W-1:0] rd_data,
    output logic             bus_err,
    output logic             busy,
    output logic             req_tgl,
    output cmd_t             pend_cmd,
    output cmd_t             direct_cmd,
    output logic             direct_valid,
    output frame_t           frame,
    output logic             coll_flag
);
    frame_t frame_q;
    cmd_t   pend_q;
    fclr_e  fclr_q;
    logic   tx_bit_q, rx_bit_q;
    logic   req_q, ack_prev_q;
    logic   bus_err_q, coll_flag_q;

    logic   busy_w, done_w, accept_w;
    cmd_t   cmd_w;

    assign busy_w   = req_q ^ ack_prev_q;
    assign done_w   = ack_tgl_sync ^ ack_prev_q;
    assign accept_w = wr_en & ~busy_w;
    assign cmd_w    = cmd_from_word(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q     <= '0;
            pend_q      <= '0;
            fclr_q      <= FCLR_NONE;
            tx_bit_q    <= 1'b0;
            rx_bit_q    <= 1'b0;
            req_q       <= 1'b0;
            ack_prev_q  <= 1'b0;
            bus_err_q   <= 1'b0;
            coll_flag_q <= 1'b0;
        end else begin
            bus_err_q  <= wr_en & busy_w;
            ack_prev_q <= ack_tgl_sync;
            if (done_w) begin
                rx_bit_q <= pend_q.rx_en;
                tx_bit_q <= pend_q.tx_en;
                fclr_q   <= FCLR_NONE;
            end
            if (accept_w) begin
                if (!port_en) begin
                    frame_q  <= frame_from_word(wr_data);
                    rx_bit_q <= cmd_w.rx_en;
                    tx_bit_q <= cmd_w.tx_en;
                end else begin
                    req_q    <= ~req_q;
                    pend_q   <= cmd_w;
                    fclr_q   <= cmd_w.fclr;
                    rx_bit_q <= rx_bit_q & cmd_w.rx_en;
                    tx_bit_q <= tx_bit_q & cmd_w.tx_en;
                end
                if (cmd_w.tx_en) coll_flag_q <= 1'b0;
            end
            if (coll_hit) begin
                tx_bit_q     <= 1'b0;
                pend_q.tx_en <= 1'b0;
                coll_flag_q  <= 1'b1;
            end
        end
    end

    assign rd_data      = word_from_state(frame_q, fclr_q, rx_bit_q, tx_bit_q);
    assign bus_err      = bus_err_q;
    assign busy         = busy_w;
    assign req_tgl      = req_q;
    assign pend_cmd     = pend_q;
    assign direct_cmd   = cmd_w;
    assign direct_valid = accept_w & ~port_en;
    assign frame        = frame_q;
    assign coll_flag    = coll_flag_q;
endmodule

// File: rtl/sctl_core_side.sv
module sctl_core_side
    import sctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_tgl_sync,
    input  cmd_t pend_cmd,
    input  logic direct_valid,
    input  cmd_t direct_cmd,
    input  logic coll_hit,
    input  logic rx_ack,
    input  logic tx_ack,
    output logic ack_tgl,
    output logic rx_core_en,
    output logic tx_core_en,
    output logic tx_fifo_clr,
    output logic rx_fifo_clr,
    output logic rx_flush,
    output lin_e lin_cmd
);
    logic req_seen_q, wait_q, ack_q;
    logic rx_en_q, tx_en_q;
    logic txclr_q, rxclr_q, flush_q;
    lin_e lin_q;

    logic arrive_w, apply_w, settled_w;
    cmd_t apply_cmd;

    assign arrive_w  = req_tgl_sync ^ req_seen_q;
    assign apply_w   = arrive_w | direct_valid;
    assign apply_cmd = arrive_w ? pend_cmd : direct_cmd;
    assign settled_w = (rx_ack == rx_en_q) && (tx_ack == tx_en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen_q <= 1'b0;
            wait_q     <= 1'b0;
            ack_q      <= 1'b0;
            rx_en_q    <= 1'b0;
            tx_en_q    <= 1'b0;
            txclr_q    <= 1'b0;
            rxclr_q    <= 1'b0;
            flush_q    <= 1'b0;
            lin_q      <= LIN_IDLE;
        end else begin
            txclr_q    <= 1'b0;
            rxclr_q    <= 1'b0;
            flush_q    <= 1'b0;
            lin_q      <= LIN_IDLE;
            req_seen_q <= req_tgl_sync;
            if (apply_w) begin
                rx_en_q <= apply_cmd.rx_en;
                tx_en_q <= apply_cmd.tx_en;
                txclr_q <= fclr_hits_tx(apply_cmd.fclr);
                rxclr_q <= fclr_hits_rx(apply_cmd.fclr);
                flush_q <= rx_en_q & ~apply_cmd.rx_en;
                lin_q   <= (apply_cmd.lin == LIN_RSVD) ? LIN_IDLE : apply_cmd.lin;
                wait_q  <= arrive_w;
            end else if (wait_q && settled_w) begin
                ack_q  <= ~ack_q;
                wait_q <= 1'b0;
            end
            if (coll_hit) tx_en_q <= 1'b0;
        end
    end

    assign ack_tgl     = ack_q;
    assign rx_core_en  = rx_en_q;
    assign tx_core_en  = tx_en_q;
    assign tx_fifo_clr = txclr_q;
    assign rx_fifo_clr = rxclr_q;
    assign rx_flush    = flush_q;
    assign lin_cmd     = lin_q;
endmodule

// File: rtl/serial_ctl_reg.sv
module serial_ctl_reg
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             bus_err,
    output logic             busy,
    input  logic             port_en,
    input  logic             data_wr,
    output logic             tx_data_wr,
    input  logic             coll_in,
    output logic             coll_flag,
    input  logic             rx_ack,
    input  logic             tx_ack,
    output logic             rx_core_en,
    output logic             tx_core_en,
    output logic             tx_fifo_clr,
    output logic             rx_fifo_clr,
    output logic             rx_flush,
    output logic [1:0]       lin_cmd,
    output logic [CSZ_W-1:0] char_size,
    output logic             two_stop,
    output logic             parity_odd,
    output logic             sof_det_en,
    output logic             ir_enc_en,
    output logic             coll_det_en
);
    frame_t frame_w;
    cmd_t   pend_w, direct_w;
    logic   direct_v_w, req_w, req_sync_w, ack_w, ack_sync_w, coll_hit_w;
    lin_e   lin_w;

    assign coll_hit_w = coll_in & frame_w.coll_det;

    sctl_host_regs u_host (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .port_en      (port_en),
        .coll_hit     (coll_hit_w),
        .ack_tgl_sync (ack_sync_w),
        .rd_data      (rd_data),
        .bus_err      (bus_err),
        .busy         (busy),
        .req_tgl      (req_w),
        .pend_cmd     (pend_w),
        .direct_cmd   (direct_w),
        .direct_valid (direct_v_w),
        .frame        (frame_w),
        .coll_flag    (coll_flag)
    );

    sctl_tgl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (clk),
        .rst     (rst),
        .tgl_in  (req_w),
        .tgl_out (req_sync_w)
    );

    sctl_core_side u_core (
        .clk          (clk),
        .rst          (rst),
        .req_tgl_sync (req_sync_w),
        .pend_cmd     (pend_w),
        .direct_valid (direct_v_w),
        .direct_cmd   (direct_w),
        .coll_hit     (coll_hit_w),
        .rx_ack       (rx_ack),
        .tx_ack       (tx_ack),
        .ack_tgl      (ack_w),
        .rx_core_en   (rx_core_en),
        .tx_core_en   (tx_core_en),
        .tx_fifo_clr  (tx_fifo_clr),
        .rx_fifo_clr  (rx_fifo_clr),
        .rx_flush     (rx_flush),
        .lin_cmd      (lin_w)
    );

    sctl_tgl_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst     (rst),
        .tgl_in  (ack_w),
        .tgl_out (ack_sync_w)
    );

    assign lin_cmd     = lin_w;
    assign tx_data_wr  = data_wr & rd_data[TXEN_BIT];
    assign char_size   = frame_w.char_size;
    assign two_stop    = frame_w.stop2;
    assign parity_odd  = frame_w.par_odd;
    assign sof_det_en  = frame_w.sof_det;
    assign ir_enc_en   = frame_w.ir_enc;
    assign coll_det_en = frame_w.coll_det;
endmodule

// File: rtl/sctl_props.sv
module sctl_props (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        port_en,
    input logic        busy,
    input logic        bus_err,
    input logic [31:0] rd_data,
    input logic        coll_in,
    input logic        coll_det_en,
    input logic        coll_flag,
    input logic        tx_core_en,
    input logic        rx_core_en,
    input logic        rx_flush,
    input logic [1:0]  lin_cmd,
    input logic [2:0]  char_size,
    input logic        two_stop,
    input logic        parity_odd,
    input logic        sof_det_en,
    input logic        ir_enc_en
);
    p_busy_write_err_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> bus_err);

    p_lin_no_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        lin_cmd != 2'b11);

    p_fifo_field_clears_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (rd_data[3:2] == 2'b00));

    p_direct_no_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && !port_en) |=> !busy);

    p_sync_write_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && port_en) |=> busy);

    p_rx_off_flush_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_core_en) |-> rx_flush);

    p_collision_r8: assert property (@(posedge clk) disable iff (rst)
        (coll_det_en && coll_in) |=> (!tx_core_en && coll_flag && !rd_data[0]));

    p_frame_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (port_en && wr_en) |=> $stable({char_size, two_stop, parity_odd,
                                         sof_det_en, ir_enc_en, coll_det_en}));
endmodule

bind serial_ctl_reg sctl_props u_props (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .port_en     (port_en),
    .busy        (busy),
    .bus_err     (bus_err),
    .rd_data     (rd_data),
    .coll_in     (coll_in),
    .coll_det_en (coll_det_en),
    .coll_flag   (coll_flag),
    .tx_core_en  (tx_core_en),
    .rx_core_en  (rx_core_en),
    .rx_flush    (rx_flush),
    .lin_cmd     (lin_cmd),
    .char_size   (char_size),
    .two_stop    (two_stop),
    .parity_odd  (parity_odd),
    .sof_det_en  (sof_det_en),
    .ir_enc_en   (ir_enc_en)
);

// File: tb/tb_serial_ctl_reg.sv
`timescale 1ns/1ps
module tb_serial_ctl_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        bus_err, busy;
    logic        port_en = 1'b0;
    logic        data_wr = 1'b0;
    logic        tx_data_wr;
    logic        coll_in = 1'b0;
    logic        coll_flag;
    logic        rx_ack = 1'b0;
    logic        tx_ack = 1'b0;
    logic        rx_core_en, tx_core_en;
    logic        tx_fifo_clr, rx_fifo_clr, rx_flush;
    logic [1:0]  lin_cmd;
    logic [2:0]  char_size;
    logic        two_stop, parity_odd, sof_det_en, ir_enc_en, coll_det_en;

    int n_chk = 0;
    int n_err = 0;
    int n_txclr = 0, n_rxclr = 0, n_brk = 0, n_hdr = 0, n_flush = 0, n_bad = 0;
    bit busy_seen = 1'b0;
    bit tx_hold = 1'b0;
    bit run_done = 1'b0;
    logic [2:0] rx_pipe = '0;
    logic [2:0] tx_pipe = '0;

    always #10 clk = ~clk;

    serial_ctl_reg #(.SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .bus_err(bus_err), .busy(busy), .port_en(port_en), .data_wr(data_wr),
        .tx_data_wr(tx_data_wr), .coll_in(coll_in), .coll_flag(coll_flag),
        .rx_ack(rx_ack), .tx_ack(tx_ack), .rx_core_en(rx_core_en),
        .tx_core_en(tx_core_en), .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr),
        .rx_flush(rx_flush), .lin_cmd(lin_cmd), .char_size(char_size),
        .two_stop(two_stop), .parity_odd(parity_odd), .sof_det_en(sof_det_en),
        .ir_enc_en(ir_enc_en), .coll_det_en(coll_det_en)
    );

    // core model: acks follow enables a few cycles later; tx ack frozen while draining
    always @(negedge clk) begin
        rx_pipe <= {rx_pipe[1:0], rx_core_en};
        rx_ack  <= rx_pipe[2];
        if (!tx_hold) begin
            tx_pipe <= {tx_pipe[1:0], tx_core_en};
            tx_ack  <= tx_pipe[2];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_fifo_clr) n_txclr++;
            if (rx_fifo_clr) n_rxclr++;
            if (rx_flush) n_flush++;
            if (lin_cmd == 2'd1) n_brk++;
            if (lin_cmd == 2'd2) n_hdr++;
            if (lin_cmd == 2'd3) n_bad++;
            if (busy) busy_seen = 1'b1;
        end
    end

    // port-off vectors: write word, read-back, pulses {txclr, rxclr, break, header, flush}
    localparam logic [31:0] VEC_W [5] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0A15,
                                          32'h0000_5526, 32'hABCD_30C0};
    localparam logic [31:0] VEC_R [5] = '{32'h0000_FF03, 32'h0000_0000, 32'h0000_0A01,
                                          32'h0000_5502, 32'h0000_3000};
    localparam logic [4:0]  VEC_P [5] = '{5'b11000, 5'b00001, 5'b10100, 5'b10010, 5'b00001};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_idle(input string req);
        for (int i = 0; i < 200; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        chk(req, {31'b0, busy}, 32'h0);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all requirements): actual hung expected completion");
            report();
        end
    end

    initial begin
        int s_tx, s_rx, s_brk, s_hdr, s_fl;
        logic [4:0] got;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 reset rd_data", rd_data, 32'h0);
        chk("R10 reset busy/err", {30'b0, busy, bus_err}, 32'h0);
        chk("R10 reset core outputs", {26'b0, tx_core_en, rx_core_en, tx_fifo_clr,
                                       rx_fifo_clr, rx_flush, coll_flag}, 32'h0);

        // port off: direct writes from the table
        for (int i = 0; i < 5; i++) begin
            s_tx = n_txclr; s_rx = n_rxclr; s_brk = n_brk; s_hdr = n_hdr; s_fl = n_flush;
            busy_seen = 1'b0;
            wr(VEC_W[i]);
            repeat (3) @(negedge clk);
            chk("R4/R9/R10 direct readback", rd_data, VEC_R[i]);
            chk("R4 core enables", {30'b0, tx_core_en, rx_core_en},
                {30'b0, VEC_R[i][0], VEC_R[i][1]});
            chk("R4 busy stays low", {31'b0, busy_seen}, 32'h0);
            got = {n_txclr != s_tx, n_rxclr != s_rx, n_brk != s_brk, n_hdr != s_hdr,
                   n_flush != s_fl};
            chk("R2/R3/R6 strobe pulses", {27'b0, got}, {27'b0, VEC_P[i]});
        end
        chk("R2 reserved line command gives no pulse", n_bad, 0);

        // port on: enable transmitter, frame write must be ignored
        port_en = 1'b1;
        wr(32'h0000_0F01);
        chk("R5 busy after accepted write", {31'b0, busy}, 32'h1);
        chk("R5/R9 tx reads 0 while pending, frame locked", rd_data, 32'h0000_3000);
        wr(32'h0000_0002);
        chk("R1 bus error on busy write", {31'b0, bus_err}, 32'h1);
        chk("R1 register unchanged", rd_data, 32'h0000_3000);
        wait_idle("R5 busy release");
        chk("R5 tx reads 1 after ack", rd_data, 32'h0000_3001);
        chk("R1 rejected rx enable not applied", {30'b0, tx_core_en, rx_core_en}, 32'h2);

        // FIFO clear with the port on, and the sync latency
        s_rx = n_rxclr;
        wr(32'h0000_0009);
        chk("R3 fifo field held while busy", {30'b0, rd_data[3:2]}, 32'h2);
        chk("R5 set bit stays 1", {31'b0, rd_data[0]}, 32'h1);
        @(negedge clk);
        chk("R11 no pulse before latency", {31'b0, rx_fifo_clr}, 32'h0);
        @(negedge clk);
        chk("R11 no pulse one cycle early", {31'b0, rx_fifo_clr}, 32'h0);
        @(negedge clk);
        chk("R11 pulse at SYNC_STAGES+1", {31'b0, rx_fifo_clr}, 32'h1);
        wait_idle("R3 busy release");
        chk("R3 fifo field clears after busy", rd_data, 32'h0000_3001);
        chk("R3 one rx fifo clear pulse", n_rxclr - s_rx, 1);

        // line header command with the port on
        s_hdr = n_hdr;
        wr(32'h0000_0021);
        chk("R2 line field reads 0", rd_data, 32'h0000_3001);
        wait_idle("R2 busy release");
        repeat (2) @(negedge clk);
        chk("R2 header pulse", n_hdr - s_hdr, 1);

        // transmitter disable drains before busy falls
        data_wr = 1'b1;
        @(negedge clk);
        chk("R7 data passes while enabled", {31'b0, tx_data_wr}, 32'h1);
        tx_hold = 1'b1;
        wr(32'h0000_0000);
        chk("R7 tx bit reads 0 at once", {31'b0, rd_data[0]}, 32'h0);
        chk("R7 data dropped after clear", {31'b0, tx_data_wr}, 32'h0);
        repeat (20) @(negedge clk);
        chk("R7 busy held during drain", {31'b0, busy}, 32'h1);
        tx_hold = 1'b0;
        wait_idle("R7 busy release after drain");
        data_wr = 1'b0;

        // receiver enable then disable
        wr(32'h0000_0002);
        chk("R5 rx reads 0 while pending", {31'b0, rd_data[1]}, 32'h0);
        wait_idle("R5 rx busy release");
        chk("R5 rx reads 1 after ack", {30'b0, rd_data[1], rx_core_en}, 32'h3);
        s_fl = n_flush;
        wr(32'h0000_0000);
        chk("R6 rx reads 0 at once", {31'b0, rd_data[1]}, 32'h0);
        wait_idle("R6 busy release");
        repeat (2) @(negedge clk);
        chk("R6 flush pulse", n_flush - s_fl, 1);

        // collision
        wr(32'h0000_0001);
        wait_idle("R8 busy release");
        @(negedge clk);
        coll_in = 1'b1;
        @(negedge clk);
        coll_in = 1'b0;
        chk("R8 collision clears tx", {29'b0, rd_data[0], tx_core_en, coll_flag}, 32'h1);
        wr(32'h0000_0001);
        chk("R8 flag cleared by tx write", {31'b0, coll_flag}, 32'h0);
        wait_idle("R8 re-enable release");
        chk("R8 tx re-enabled", {31'b0, rd_data[0]}, 32'h1);

        run_done = 1'b1;
        report();
    end
endmodule